// File: doc/BRIEF.md
# Prescaled Reload Modulo Timer

A 16-bit up-counting timer behind a small 32-bit register interface. Software picks a count clock with a source field and a power-of-two prescaler. The counter climbs until it matches a programmed limit. On the next count step it reloads a programmed start value instead of incrementing, and it raises an overflow flag. Together with an enable bit, that flag drives a registered interrupt line.

Software reads the live count to keep time. It reprograms the limit to schedule one-shot or periodic events: with a start value of 0, a period of N steps needs a limit of N-1. The limit and start registers are double-buffered. Writes land in a holding copy, and the copy used for counting is refreshed only while the count clock is switched off. This lets software stage new values without disturbing a running period. Writing anything to the count register restarts the period from the start value.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is 0.
- R2: Registers sit at byte offsets 0x00 control, 0x04 count, 0x08 limit and 0x4C start. The control layout is: bits [2:0] prescaler exponent, [4:3] source, bit 6 interrupt enable, bit 7 overflow flag. Bit 5, all upper bits, the upper half of the count read and any unmapped offset read as 0. Reads are combinational from the current state.
- R3: A source value of 1 lets the counter run. Values 0, 2 and 3 hold the count unchanged.
- R4: While running, the counter takes one step every 2^P clock cycles, where P is the exponent. The divider is cleared whenever the source is not 1, so the first step comes 2^P cycles after the source write takes effect.
- R5: A step adds 1, modulo 2^16, unless the count equals the active limit. In that case the step loads the active start value.
- R6: The overflow flag is set by each step that loads the start value, and by no other event.
- R7: A control write with bit 7 = 0 clears the flag, and one with bit 7 = 1 leaves it unchanged. A set in the same cycle as a clearing write wins.
- R8: `irq` equals flag AND enable as they were one cycle earlier.
- R9: A write of any data to the count register loads the active start value on that edge. It overrides a coinciding step, which then sets no flag.
- R10: Writes to limit and start go to holding copies. The active copies, which are the ones read back and used for counting, are refreshed from the holding copies on every edge at which the source is 0. They stay unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Registered overflow interrupt, active high |

## Verification
The assertions assume the bus presents at most one write per cycle and that `addr` and `wdata` are stable around the clock edge. The bench's reference model further assumes the prescaler exponent is changed only while the source is 0, because a change mid-run shifts the phase of the free-running divider. The stimulus keeps to both rules: every exponent change is preceded by a write that stops the source. Clearing writes and count writes are swept across every phase of short periods, so they collide with flag sets and reload steps.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
    localparam int CNT_W  = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int PS_W   = 3;
    localparam int DIV_W  = (1 << PS_W) - 1;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_COUNT = 'h04;
    localparam int OFS_LIMIT = 'h08;
    localparam int OFS_START = 'h4C;

    localparam int BIT_IE   = 6;
    localparam int BIT_FLAG = 7;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_RSV2 = 2'd2,
        SRC_RSV3 = 2'd3
    } src_e;

    typedef struct packed {
        logic            ie;
        src_e            src;
        logic [PS_W-1:0] psc;
    } ctrl_t;

    function automatic logic [DIV_W-1:0] div_mask(input logic [PS_W-1:0] e);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++) m[i] = (i < int'(e));
        return m;
    endfunction
endpackage

// File: rtl/rtimer_prescale.sv
module rtimer_prescale #(
    parameter int PS_W = rtimer_pkg::PS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] psc,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(psc));
    end

    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    // R4: divider restarts from zero whenever the counter is stopped
    assert_div_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (div_q == '0));
    // R4: with an exponent above zero, the first cycle after stopping never steps
    assert_no_early_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && psc != '0) |=> !tick);
endmodule

// File: rtl/rtimer_dbuf.sv
module rtimer_dbuf #(
    parameter int W = rtimer_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         open,
    output logic [W-1:0] act
);
    logic [W-1:0] hold_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr)   hold_q <= din;
            if (open) act_q  <= hold_q;
        end
    end

    assign act = act_q;

    // R10: active copy frozen while the count clock is on
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !open |=> $stable(act_q));
    // R10: active copy tracks the holding copy while the clock is off
    assert_follow_R10: assert property (@(posedge clk) disable iff (rst)
        open |=> (act_q == $past(hold_q)));
endmodule

// File: rtl/rtimer_core.sv
module rtimer_core #(
    parameter int CNT_W = rtimer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] start,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wrap;

    assign wrap = tick && !load && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (load)      cnt_q <= start;
            else if (wrap) cnt_q <= start;
            else if (tick) cnt_q <= cnt_q + 1'b1;

            if (wrap)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q != limit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == $past(start)));
    assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(start)));
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag_q);
    assert_flag_only_R6: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !flag_q) |=> !flag_q);
    assert_flag_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !wrap) |=> !flag_q);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int CNT_W  = rtimer_pkg::CNT_W,
    parameter int BUS_W  = rtimer_pkg::BUS_W,
    parameter int ADDR_W = rtimer_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);
    import rtimer_pkg::*;

    ctrl_t            ctrl_q;
    logic             irq_q;
    logic             sel_ctrl, sel_count, sel_limit, sel_start;
    logic             run, off, tick, flag;
    logic [CNT_W-1:0] cnt, limit_act, start_act;

    assign sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign sel_count = (addr == ADDR_W'(OFS_COUNT));
    assign sel_limit = (addr == ADDR_W'(OFS_LIMIT));
    assign sel_start = (addr == ADDR_W'(OFS_START));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_en && sel_ctrl) begin
                ctrl_q.psc <= wdata[PS_W-1:0];
                ctrl_q.src <= src_e'(wdata[4:3]);
                ctrl_q.ie  <= wdata[BIT_IE];
            end
            irq_q <= flag && ctrl_q.ie;
        end
    end

    assign run = (ctrl_q.src == SRC_SYS);
    assign off = (ctrl_q.src == SRC_OFF);
    assign irq = irq_q;

    rtimer_prescale #(.PS_W(PS_W)) u_pre (
        .clk (clk), .rst (rst), .run (run), .psc (ctrl_q.psc), .tick (tick)
    );

    rtimer_dbuf #(.W(CNT_W)) u_limit (
        .clk (clk), .rst (rst), .wr (wr_en && sel_limit),
        .din (wdata[CNT_W-1:0]), .open (off), .act (limit_act)
    );

    rtimer_dbuf #(.W(CNT_W)) u_start (
        .clk (clk), .rst (rst), .wr (wr_en && sel_start),
        .din (wdata[CNT_W-1:0]), .open (off), .act (start_act)
    );

    rtimer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_en && sel_count),
        .flag_clr (wr_en && sel_ctrl && !wdata[BIT_FLAG]),
        .limit    (limit_act),
        .start    (start_act),
        .cnt      (cnt),
        .flag     (flag)
    );

    always_comb begin
        rdata = '0;
        if (sel_ctrl)       rdata = BUS_W'({flag, ctrl_q.ie, 1'b0, ctrl_q.src, ctrl_q.psc});
        else if (sel_count) rdata = BUS_W'(cnt);
        else if (sel_limit) rdata = BUS_W'(limit_act);
        else if (sel_start) rdata = BUS_W'(start_act);
    end

    // R8: interrupt stays low one cycle after the enable is off
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.ie |=> !irq_q);
    // R8: interrupt follows a set flag with enable on
    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && ctrl_q.ie) |=> irq_q);
    // R3: a stopped or reserved source never steps the counter
    assert_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !(wr_en && sel_count)) |=> $stable(cnt));
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    reload_timer dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .irq (irq)
    );

    always #5 clk = ~clk;

    // reference model state
    int m_psc, m_src, m_ie, m_flag, m_irq, m_cnt, m_lim, m_sta, m_limh, m_stah, m_pc;
    int compared = 0, mismatched = 0, cycles = 0;
    string tag = "R1";

    always @(posedge clk) begin
        int tk, wrap, n_cnt, n_flag;
        cycles++;
        if (rst) begin
            m_psc = 0; m_src = 0; m_ie = 0; m_flag = 0; m_irq = 0;
            m_cnt = 0; m_lim = 0; m_sta = 0; m_limh = 0; m_stah = 0; m_pc = 0;
        end else begin
            tk = 0;
            if (m_src == 1) begin
                m_pc++;
                if (m_pc == (1 << m_psc)) begin tk = 1; m_pc = 0; end
            end else m_pc = 0;
            n_cnt = m_cnt; n_flag = m_flag; wrap = 0;
            if (wr_en && addr == 8'h04) n_cnt = m_sta;
            else if (tk) begin
                if (m_cnt == m_lim) begin n_cnt = m_sta; wrap = 1; end
                else n_cnt = (m_cnt + 1) % 65536;
            end
            if (wrap) n_flag = 1;
            else if (wr_en && addr == 8'h00 && !wdata[7]) n_flag = 0;
            m_irq = m_flag & m_ie;
            if (m_src == 0) begin m_lim = m_limh; m_sta = m_stah; end
            if (wr_en && addr == 8'h00) begin
                m_psc = int'(wdata[2:0]); m_src = int'(wdata[4:3]); m_ie = int'(wdata[6]);
            end
            if (wr_en && addr == 8'h08) m_limh = int'(wdata[15:0]);
            if (wr_en && addr == 8'h4C) m_stah = int'(wdata[15:0]);
            m_cnt = n_cnt; m_flag = n_flag;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return 32'((m_flag << 7) | (m_ie << 6) | (m_src << 3) | m_psc);
            8'h04: return 32'(m_cnt);
            8'h08: return 32'(m_lim);
            8'h4C: return 32'(m_sta);
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        compared++;
        if (rdata !== exp_rd(addr)) begin
            mismatched++;
            $display("FAIL %s rdata @%h actual=%h expected=%h", tag, addr, rdata, exp_rd(addr));
        end
        compared++;
        if (irq !== m_irq[0]) begin
            mismatched++;
            $display("FAIL %s irq actual=%0d expected=%0d", tag, irq, m_irq);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!rst) compare();
        wr_en = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        idle(1, 8'h00); idle(1, 8'h04); idle(1, 8'h08); idle(1, 8'h4C);
        tag = "R2";
        idle(1, 8'h10);
        cyc(1'b1, 8'h00, 32'hFFFF_FF27); idle(2, 8'h00);
        cyc(1'b1, 8'h00, 32'h0); idle(1, 8'h00);
        tag = "R10";
        cyc(1'b1, 8'h08, 32'hABCD_0004); cyc(1'b1, 8'h4C, 32'h0); idle(3, 8'h08);
        tag = "R6";
        cyc(1'b1, 8'h00, 32'h49); idle(14, 8'h04);
        tag = "R8";
        idle(4, 8'h00);
        tag = "R7";
        for (int k = 0; k < 12; k++) begin
            cyc(1'b1, 8'h00, (k % 2) ? 32'hC9 : 32'h49);
            idle(k % 5, 8'h00);
        end
        tag = "R4";
        cyc(1'b1, 8'h00, 32'h0);
        cyc(1'b1, 8'h00, 32'h4A); idle(30, 8'h04);
        cyc(1'b1, 8'h00, 32'h0);
        cyc(1'b1, 8'h00, 32'h4B); idle(40, 8'h04);
        tag = "R10";
        cyc(1'b1, 8'h08, 32'h2); idle(6, 8'h08);
        cyc(1'b1, 8'h4C, 32'h7); idle(3, 8'h4C);
        cyc(1'b1, 8'h00, 32'h0); idle(2, 8'h08); idle(1, 8'h4C);
        tag = "R5";
        cyc(1'b1, 8'h4C, 32'd10); cyc(1'b1, 8'h08, 32'd13); idle(1, 8'h04);
        cyc(1'b1, 8'h00, 32'h48); idle(12, 8'h04);
        tag = "R9";
        for (int k = 0; k < 10; k++) begin
            cyc(1'b1, 8'h04, 32'hDEAD_0000 + 32'(k)); idle(k % 6, 8'h04);
        end
        idle(2, 8'h00);
        tag = "R3";
        cyc(1'b1, 8'h00, 32'h50); idle(6, 8'h04);
        cyc(1'b1, 8'h00, 32'h58); idle(6, 8'h04);
        cyc(1'b1, 8'h04, 32'h1); idle(3, 8'h04);
        tag = "R8";
        cyc(1'b1, 8'h00, 32'h08); idle(10, 8'h00);
        tag = "R5";
        cyc(1'b1, 8'h00, 32'h0);
        cyc(1'b1, 8'h4C, 32'hFFF0); cyc(1'b1, 8'h08, 32'hFFFF); idle(1, 8'h04);
        cyc(1'b1, 8'h04, 32'h0);
        cyc(1'b1, 8'h00, 32'h48); idle(40, 8'h04);
        cyc(1'b1, 8'h00, 32'h0);
        cyc(1'b1, 8'h4C, 32'd20); cyc(1'b1, 8'h08, 32'd5); idle(1, 8'h04);
        cyc(1'b1, 8'h04, 32'h0);
        cyc(1'b1, 8'h00, 32'h48); idle(65560, 8'h04);
        idle(2, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule